// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is one channel of a DMA engine. It moves elements between a memory region and a single fixed device address. Each element is 1, 2 or 4 bytes wide. On the memory side the address advances by the element width after every element. The device address never changes. Each element is paced by a request/acknowledge handshake with the peripheral. Accesses leave on a word-wide master port that carries one outstanding access at a time.

A transfer is described by four 32-bit words, held in this order: device address, memory address, size, link. A configuration write carries all four words, the direction and a mode. Mode 2 runs the descriptor just written and stops. Mode 1 treats the link word as a pointer and walks a chain of descriptors fetched from memory. Writing mode 0 during a run stops the channel at once.

The channel shows a 2-bit activity code, its current mode, and three one-cycle pulses:
- an interrupt pulse,
- an error pulse,
- the device acknowledge.

Top module: `lnk_dma_chan`

## Requirements
- R1: After reset the activity code is 0, the mode is 0 and every pulse output and `m_req` are low.
- R2: In chained mode the channel reads four words from the link pointer with its two low bits cleared, at offsets 0, 4, 8 and 12. It reads them as device address, memory address, size word and link word, and shows activity code 1 during the fetch. `m_addr` and `m_we` hold steady until `m_ack`.
- R3: Size word bits 13:12 select the width: 3 is 1 byte (`m_size`=0), 2 is 2 bytes (`m_size`=1), 0 is 4 bytes (`m_size`=2). Bits 11:0 give the element count. Data is right-justified on the bus. The memory address steps by the width after every element.
- R4: A size word is rejected when any of the following holds. Rejection gives an error pulse and an interrupt pulse, returns the channel to idle and makes no data access.
  - The width code is 1.
  - Any bit above 13 is set.
  - The count exceeds 0x3FF at 1 or 2 bytes.
  - The count exceeds 0x7FF at 4 bytes.
- R5: Link word bit 1 means another descriptor follows at the address in bits 31:2 (times 4). Bit 0 requests an interrupt pulse once that descriptor's elements are done.
- R6: In single mode (mode 2) the channel runs the written descriptor only. It ignores link bit 1, fetches nothing and finishes idle.
- R7: Direction 1 reads the memory address and writes the device address. Direction 0 reads the device address and writes the memory address.
- R8: Activity codes are 0 idle, 1 descriptor, 2 waiting for the device, 3 data access. Each element waits in code 2 with no bus request until `dev_req` is high.
- R9: `dev_ack` pulses for one cycle per element, one cycle after the element's write is accepted without error.
- R10: A configuration write of mode 0 while the channel is active returns it to idle with mode 0 on the next cycle. It raises no interrupt or error pulse and makes no further bus request.
- R11: An error response on any fetch or data access gives an error pulse and an interrupt pulse, and returns the channel to idle with mode 0.
- R12: When the last descriptor finishes, the channel goes idle and the mode reverts to 0. A descriptor with count 0 finishes without any data access.
- R13: A configuration write with a nonzero mode while the channel is active is ignored. The mode and the descriptor in progress are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | 0 stop, 1 chained, 2 single |
| cfg_dir | input | 1 | 1 memory to device, 0 device to memory |
| cfg_dev | input | 32 | Device address word |
| cfg_mem | input | 32 | Memory address word |
| cfg_size | input | 32 | Size word (width and count) |
| cfg_next | input | 32 | Link word / chain pointer |
| state_o | output | 2 | Activity code |
| mode_o | output | 2 | Current mode |
| irq_o | output | 1 | Interrupt pulse |
| err_o | output | 1 | Error pulse |
| m_req | output | 1 | Bus request |
| m_we | output | 1 | Bus write |
| m_addr | output | 32 | Bus byte address |
| m_size | output | 2 | Access width code |
| m_wdata | output | 32 | Write data, right-justified |
| m_ack | input | 1 | Access accepted; read data and error valid |
| m_err | input | 1 | Error response |
| m_rdata | input | 32 | Read data, right-justified |
| dev_req | input | 1 | Device ready for an element |
| dev_ack | output | 1 | Element done pulse |

## Verification
A wrong fetch index or link pointer shows within one descriptor. The bus addresses go wrong and the bytes land in the wrong memory locations. A wrong element counter or address step shows as a wrong number of `dev_ack` pulses or shifted data once the descriptor completes. A wrong end-of-descriptor decision shows a few cycles later as a missing or extra interrupt pulse, a mode that fails to revert, or a fetch that should not have occurred. Abort and error handling appear on the very next cycle in the activity code and mode.

// File: rtl/lnk_dma_pkg.sv
package lnk_dma_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_EVAL,
      ST_WAIT,
      ST_RD,
      ST_WR
   } ch_st_e;

   localparam logic [1:0] MODE_OFF    = 2'd0;
   localparam logic [1:0] MODE_CHAIN  = 2'd1;
   localparam logic [1:0] MODE_SINGLE = 2'd2;

   localparam logic [1:0] CODE_IDLE = 2'd0;
   localparam logic [1:0] CODE_DESC = 2'd1;
   localparam logic [1:0] CODE_WAIT = 2'd2;
   localparam logic [1:0] CODE_XFER = 2'd3;

   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam logic [1:0] SZ_HALF = 2'd1;
   localparam logic [1:0] SZ_WORD = 2'd2;

   function automatic logic [1:0] st_code(input ch_st_e s);
      case (s)
         ST_FETCH, ST_EVAL: return CODE_DESC;
         ST_WAIT:           return CODE_WAIT;
         ST_RD, ST_WR:      return CODE_XFER;
         default:           return CODE_IDLE;
      endcase
   endfunction

endpackage

// File: rtl/lnk_dma_size_dec.sv
module lnk_dma_size_dec
   import lnk_dma_pkg::*;
#(
   parameter int DW         = 32,
   parameter int CNT_W      = 12,
   parameter int WSEL_LSB   = 12,
   parameter int MAX_NARROW = 'h3FF,
   parameter int MAX_WIDE   = 'h7FF
) (
   input  logic [DW-1:0]    size_word,
   output logic [1:0]       sz,
   output logic [2:0]       step,
   output logic [CNT_W-1:0] cnt,
   output logic             bad
);

   localparam logic [CNT_W-1:0] LIM_N = CNT_W'(MAX_NARROW);
   localparam logic [CNT_W-1:0] LIM_W = CNT_W'(MAX_WIDE);

   if (WSEL_LSB < CNT_W) begin : g_chk_overlap
      $error("width select overlaps count field");
   end
   if (WSEL_LSB + 2 >= DW) begin : g_chk_room
      $error("size word too narrow for width select");
   end
   if (MAX_WIDE >= (1 << CNT_W) || MAX_NARROW > MAX_WIDE) begin : g_chk_lim
      $error("count limits do not fit count field");
   end

   logic [1:0] wsel;
   logic       rsvd;

   assign wsel = size_word[WSEL_LSB+1:WSEL_LSB];
   assign rsvd = |size_word[DW-1:WSEL_LSB+2];
   assign cnt  = size_word[CNT_W-1:0];

   always_comb begin
      sz   = SZ_WORD;
      step = 3'd4;
      bad  = rsvd;
      case (wsel)
         2'b11: begin
            sz   = SZ_BYTE;
            step = 3'd1;
            bad  = rsvd || (cnt > LIM_N);
         end
         2'b10: begin
            sz   = SZ_HALF;
            step = 3'd2;
            bad  = rsvd || (cnt > LIM_N);
         end
         2'b00: begin
            sz   = SZ_WORD;
            step = 3'd4;
            bad  = rsvd || (cnt > LIM_W);
         end
         default: bad = 1'b1;
      endcase
   end

endmodule

// File: rtl/lnk_dma_desc_bank.sv
module lnk_dma_desc_bank #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_all,
   input  logic [DW-1:0] ld_dev,
   input  logic [DW-1:0] ld_mem,
   input  logic [DW-1:0] ld_size,
   input  logic [DW-1:0] ld_next,
   input  logic          wr_en,
   input  logic [1:0]    wr_idx,
   input  logic [DW-1:0] wr_word,
   output logic [DW-1:0] q_dev,
   output logic [DW-1:0] q_mem,
   output logic [DW-1:0] q_size,
   output logic [DW-1:0] q_next
);

   localparam int NWORDS = 4;

   logic [DW-1:0] ld_w   [NWORDS];
   logic [DW-1:0] bank_q [NWORDS];

   assign ld_w[0] = ld_dev;
   assign ld_w[1] = ld_mem;
   assign ld_w[2] = ld_size;
   assign ld_w[3] = ld_next;

   for (genvar g = 0; g < NWORDS; g++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bank_q[g] <= '0;
         else if (load_all)
            bank_q[g] <= ld_w[g];
         else if (wr_en && (wr_idx == 2'(g)))
            bank_q[g] <= wr_word;
      end
   end

   assign q_dev  = bank_q[0];
   assign q_mem  = bank_q[1];
   assign q_size = bank_q[2];
   assign q_next = bank_q[3];

   // R2: a fetched word never lands in the same cycle as a full configuration load
   p_no_dual_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(load_all && wr_en));

endmodule

// File: rtl/lnk_dma_walker.sv
module lnk_dma_walker #(
   parameter int AW    = 32,
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [AW-1:0]    load_addr,
   input  logic [CNT_W-1:0] load_cnt,
   input  logic [2:0]       step,
   input  logic             adv,
   output logic [AW-1:0]    addr,
   output logic             last
);

   logic [CNT_W-1:0] rem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr  <= '0;
         rem_q <= '0;
      end else if (load) begin
         addr  <= load_addr;
         rem_q <= load_cnt;
      end else if (adv) begin
         addr  <= addr + AW'(step);
         rem_q <= rem_q - 1'b1;
      end
   end

   assign last = (rem_q == CNT_W'(1));

   // R9: an element only completes while elements remain
   p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      adv |-> (rem_q != '0));

endmodule

// File: rtl/lnk_dma_chan.sv
module lnk_dma_chan
   import lnk_dma_pkg::*;
#(
   parameter int AW         = 32,
   parameter int DW         = 32,
   parameter int CNT_W      = 12,
   parameter int WSEL_LSB   = 12,
   parameter int MAX_NARROW = 'h3FF,
   parameter int MAX_WIDE   = 'h7FF
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [1:0]    cfg_mode,
   input  logic          cfg_dir,
   input  logic [AW-1:0] cfg_dev,
   input  logic [AW-1:0] cfg_mem,
   input  logic [DW-1:0] cfg_size,
   input  logic [AW-1:0] cfg_next,
   output logic [1:0]    state_o,
   output logic [1:0]    mode_o,
   output logic          irq_o,
   output logic          err_o,
   output logic          m_req,
   output logic          m_we,
   output logic [AW-1:0] m_addr,
   output logic [1:0]    m_size,
   output logic [DW-1:0] m_wdata,
   input  logic          m_ack,
   input  logic          m_err,
   input  logic [DW-1:0] m_rdata,
   input  logic          dev_req,
   output logic          dev_ack
);

   if (AW > DW || AW < 4) begin : g_chk_aw
      $error("address width must fit a descriptor word");
   end

   ch_st_e        st_q;
   logic [1:0]    mode_q;
   logic          dir_q;
   logic [1:0]    widx_q;
   logic [AW-1:0] link_q;
   logic [DW-1:0] hold_q;
   logic          irq_q, err_q, ack_q;

   logic [DW-1:0]    d_dev, d_mem, d_size, d_next;
   logic [1:0]       w_sz;
   logic [2:0]       w_step;
   logic [CNT_W-1:0] w_cnt;
   logic             w_bad;
   logic [AW-1:0]    walk_addr;
   logic             walk_last;

   logic busy, abort, start, on_bus, acc_ok, bus_fail, size_fail;
   logic elem_done, desc_end, follow;

   assign busy      = (st_q != ST_IDLE);
   assign abort     = cfg_we && (cfg_mode == MODE_OFF) && busy;
   assign start     = cfg_we && !busy &&
                      ((cfg_mode == MODE_CHAIN) || (cfg_mode == MODE_SINGLE));
   assign on_bus    = (st_q == ST_FETCH) || (st_q == ST_RD) || (st_q == ST_WR);
   assign acc_ok    = on_bus && m_ack && !m_err && !abort;
   assign bus_fail  = on_bus && m_ack && m_err;
   assign size_fail = (st_q == ST_EVAL) && w_bad;
   assign elem_done = (st_q == ST_WR) && acc_ok;
   assign desc_end  = ((st_q == ST_EVAL) && !w_bad && (w_cnt == '0)) ||
                      (elem_done && walk_last);
   assign follow    = (mode_q == MODE_CHAIN) && d_next[1];

   lnk_dma_desc_bank #(.DW(DW)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_all (start),
      .ld_dev   (DW'(cfg_dev)),
      .ld_mem   (DW'(cfg_mem)),
      .ld_size  (cfg_size),
      .ld_next  (DW'(cfg_next)),
      .wr_en    ((st_q == ST_FETCH) && acc_ok),
      .wr_idx   (widx_q),
      .wr_word  (m_rdata),
      .q_dev    (d_dev),
      .q_mem    (d_mem),
      .q_size   (d_size),
      .q_next   (d_next)
   );

   lnk_dma_size_dec #(
      .DW(DW), .CNT_W(CNT_W), .WSEL_LSB(WSEL_LSB),
      .MAX_NARROW(MAX_NARROW), .MAX_WIDE(MAX_WIDE)
   ) u_dec (
      .size_word (d_size),
      .sz        (w_sz),
      .step      (w_step),
      .cnt       (w_cnt),
      .bad       (w_bad)
   );

   lnk_dma_walker #(.AW(AW), .CNT_W(CNT_W)) u_walk (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      ((st_q == ST_EVAL) && !abort),
      .load_addr (d_mem[AW-1:0]),
      .load_cnt  (w_cnt),
      .step      (w_step),
      .adv       (elem_done),
      .addr      (walk_addr),
      .last      (walk_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         mode_q <= MODE_OFF;
         dir_q  <= 1'b0;
         widx_q <= '0;
         link_q <= '0;
         hold_q <= '0;
      end else if (abort) begin
         st_q   <= ST_IDLE;
         mode_q <= MODE_OFF;
      end else begin
         case (st_q)
            ST_IDLE: if (start) begin
               mode_q <= cfg_mode;
               dir_q  <= cfg_dir;
               link_q <= {cfg_next[AW-1:2], 2'b00};
               widx_q <= '0;
               st_q   <= (cfg_mode == MODE_CHAIN) ? ST_FETCH : ST_EVAL;
            end
            ST_FETCH: if (m_ack) begin
               if (m_err) begin
                  st_q   <= ST_IDLE;
                  mode_q <= MODE_OFF;
               end else begin
                  widx_q <= widx_q + 2'd1;
                  if (widx_q == 2'd3) st_q <= ST_EVAL;
               end
            end
            ST_EVAL: begin
               if (w_bad) begin
                  st_q   <= ST_IDLE;
                  mode_q <= MODE_OFF;
               end else if (w_cnt != '0) begin
                  st_q <= ST_WAIT;
               end
            end
            ST_WAIT: if (dev_req) st_q <= ST_RD;
            ST_RD: if (m_ack) begin
               if (m_err) begin
                  st_q   <= ST_IDLE;
                  mode_q <= MODE_OFF;
               end else begin
                  hold_q <= m_rdata;
                  st_q   <= ST_WR;
               end
            end
            ST_WR: if (m_ack) begin
               if (m_err) begin
                  st_q   <= ST_IDLE;
                  mode_q <= MODE_OFF;
               end else if (!walk_last) begin
                  st_q <= ST_WAIT;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
         if (desc_end) begin
            if (follow) begin
               link_q <= {d_next[AW-1:2], 2'b00};
               widx_q <= '0;
               st_q   <= ST_FETCH;
            end else begin
               st_q   <= ST_IDLE;
               mode_q <= MODE_OFF;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
         err_q <= 1'b0;
         ack_q <= 1'b0;
      end else begin
         irq_q <= !abort && ((desc_end && d_next[0]) || bus_fail || size_fail);
         err_q <= !abort && (bus_fail || size_fail);
         ack_q <= elem_done;
      end
   end

   always_comb begin
      m_addr = '0;
      m_size = w_sz;
      case (st_q)
         ST_FETCH: begin
            m_addr = link_q + AW'({widx_q, 2'b00});
            m_size = SZ_WORD;
         end
         ST_RD:   m_addr = dir_q ? walk_addr : d_dev[AW-1:0];
         ST_WR:   m_addr = dir_q ? d_dev[AW-1:0] : walk_addr;
         default: m_addr = '0;
      endcase
   end

   assign m_req   = on_bus;
   assign m_we    = (st_q == ST_WR);
   assign m_wdata = hold_q;
   assign state_o = st_code(st_q);
   assign mode_o  = mode_q;
   assign irq_o   = irq_q;
   assign err_o   = err_q;
   assign dev_ack = ack_q;

   // R8: no bus traffic while idle or waiting on the device
   p_quiet_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_o == CODE_IDLE) || (state_o == CODE_WAIT)) |-> !m_req);

   // R2: an unanswered request holds its address and direction
   p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (m_req && !m_ack && !abort) |=> (m_req && $stable(m_addr) && $stable(m_we)));

   // R10: stop request lands on the next cycle, silently
   p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> ((state_o == CODE_IDLE) && (mode_o == MODE_OFF) && !irq_o && !err_o));

   // R11: every error pulse comes with an interrupt pulse and an idle channel
   p_err_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (irq_o && (state_o == CODE_IDLE)));

   // R9: device acknowledge is a single-cycle pulse after an accepted write
   p_ack_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      dev_ack |=> !dev_ack);
   p_ack_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
      dev_ack |-> $past(m_req && m_we && m_ack && !m_err));

   // R12: an idle channel always shows mode 0
   p_idle_mode_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == CODE_IDLE) |-> (mode_o == MODE_OFF));

endmodule

// File: tb/sim_lnk_dma_chan.sv
`timescale 1ns/1ps
module sim_lnk_dma_chan;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_mode = 2'd0;
   logic        cfg_dir = 1'b0;
   logic [31:0] cfg_dev = '0, cfg_mem = '0, cfg_size = '0, cfg_next = '0;
   logic [1:0]  state_o, mode_o, m_size;
   logic        irq_o, err_o, m_req, m_we, dev_ack;
   logic [31:0] m_addr, m_wdata;
   logic        m_ack = 1'b0, m_err = 1'b0;
   logic [31:0] m_rdata = '0;
   logic        dev_req = 1'b1;

   always #2.5 clk = ~clk;

   lnk_dma_chan u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
      .cfg_dir(cfg_dir), .cfg_dev(cfg_dev), .cfg_mem(cfg_mem),
      .cfg_size(cfg_size), .cfg_next(cfg_next), .state_o(state_o),
      .mode_o(mode_o), .irq_o(irq_o), .err_o(err_o), .m_req(m_req),
      .m_we(m_we), .m_addr(m_addr), .m_size(m_size), .m_wdata(m_wdata),
      .m_ack(m_ack), .m_err(m_err), .m_rdata(m_rdata), .dev_req(dev_req),
      .dev_ack(dev_ack)
   );

   localparam logic [31:0] DEVA = 32'h0000_00F0;

   logic [7:0]  mem [256];
   logic [31:0] rd_log [32];
   logic [31:0] dev_log [16];
   int          n_rd, n_dw, n_irq, n_err, n_ack, n_chk, n_fail;
   logic [7:0]  dev_cnt;
   logic [31:0] err_addr = 32'hFFFF_FFFF;

   // bus and device model plus pulse counters, all at the falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (irq_o)   n_irq++;
         if (err_o)   n_err++;
         if (dev_ack) n_ack++;
      end
      if (m_ack) begin
         m_ack = 1'b0;
         m_err = 1'b0;
      end else if (m_req) begin
         m_ack = 1'b1;
         m_err = (m_addr == err_addr);
         if (!m_err) begin
            if (!m_we) begin
               rd_log[n_rd[4:0]] = m_addr;
               n_rd++;
               if (m_addr == DEVA) begin
                  m_rdata = {16'h0, 8'h5A, dev_cnt};
                  dev_cnt++;
               end else begin
                  m_rdata = {mem[8'(m_addr[7:0]+8'd3)], mem[8'(m_addr[7:0]+8'd2)],
                             mem[8'(m_addr[7:0]+8'd1)], mem[m_addr[7:0]]};
               end
            end else if (m_addr == DEVA) begin
               dev_log[n_dw[3:0]] = m_wdata;
               n_dw++;
            end else begin
               for (int b = 0; b < 4; b++)
                  if (b < (1 << m_size)) mem[8'(m_addr[7:0] + 8'(b))] = m_wdata[8*b +: 8];
            end
         end
      end
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic put32(input int a, input logic [31:0] v);
      for (int b = 0; b < 4; b++) mem[a + b] = v[8*b +: 8];
   endtask

   function automatic logic [31:0] get32(input int a);
      return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
   endfunction

   task automatic clr();
      n_rd = 0; n_dw = 0; n_irq = 0; n_err = 0; n_ack = 0; dev_cnt = 8'd1;
      err_addr = 32'hFFFF_FFFF;
   endtask

   task automatic cfg(input logic [1:0] md, input logic dr, input logic [31:0] dv,
                      input logic [31:0] mm, input logic [31:0] sz, input logic [31:0] nx);
      @(negedge clk);
      cfg_mode = md; cfg_dir = dr; cfg_dev = dv; cfg_mem = mm;
      cfg_size = sz; cfg_next = nx; cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic wait_idle(input string req);
      int k;
      for (k = 0; k < 3000; k++) begin
         @(negedge clk);
         if (state_o == 2'd0) break;
      end
      chk(req, "reaches idle", 32'(k < 3000), 32'd1);
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1", "state", 32'(state_o), 32'd0);
      chk("R1", "mode", 32'(mode_o), 32'd0);
      chk("R1", "pulses and req", {28'd0, irq_o, err_o, dev_ack, m_req}, 32'd0);
   endtask

   task automatic t_single_m2d();
      clr();
      put32(8'h40, 32'h1122_3344); put32(8'h44, 32'h5566_7788); put32(8'h48, 32'h99AA_BBCC);
      cfg(2'd2, 1'b1, DEVA, 32'h40, 32'h0000_0003, 32'h1);
      wait_idle("R7");
      chk("R7", "device writes", 32'(n_dw), 32'd3);
      chk("R3", "word 0 to device", dev_log[0], 32'h1122_3344);
      chk("R3", "word 2 to device", dev_log[2], 32'h99AA_BBCC);
      chk("R9", "ack pulses", 32'(n_ack), 32'd3);
      chk("R5", "irq on end code 1", 32'(n_irq), 32'd1);
      chk("R12", "mode reverts", 32'(mode_o), 32'd0);
   endtask

   task automatic t_chain_d2m();
      clr();
      for (int i = 0; i < 8; i++) mem[8'h20 + i] = 8'hEE;
      for (int i = 0; i < 8; i++) mem[8'h30 + i] = 8'hEE;
      put32(8'h80, DEVA); put32(8'h84, 32'h20); put32(8'h88, 32'h3003); put32(8'h8C, 32'h93);
      put32(8'h90, DEVA); put32(8'h94, 32'h30); put32(8'h98, 32'h2002); put32(8'h9C, 32'h0);
      cfg(2'd1, 1'b0, 32'h0, 32'h0, 32'h0, 32'h82);
      wait_idle("R2");
      chk("R2", "fetch word 0 addr", rd_log[0], 32'h80);
      chk("R2", "fetch word 3 addr", rd_log[3], 32'h8C);
      chk("R5", "follows link", rd_log[7], 32'h90);
      chk("R3", "byte elements", {8'h0, mem[8'h20], mem[8'h21], mem[8'h22]}, 32'h0001_0203);
      chk("R3", "byte width limit", 32'(mem[8'h23]), 32'hEE);
      chk("R3", "half elements", get32(8'h30), 32'h5A05_5A04);
      chk("R7", "device reads", 32'(dev_cnt), 32'd6);
      chk("R9", "ack pulses", 32'(n_ack), 32'd5);
      chk("R5", "only first descriptor irqs", 32'(n_irq), 32'd1);
   endtask

   task automatic t_single_ignores_link();
      clr();
      put32(8'h40, 32'hCAFE_F00D);
      cfg(2'd2, 1'b1, DEVA, 32'h40, 32'h0000_0001, 32'h82);
      wait_idle("R6");
      chk("R6", "no fetch, one read", 32'(n_rd), 32'd1);
      chk("R6", "element moved", dev_log[0], 32'hCAFE_F00D);
      chk("R6", "no irq", 32'(n_irq), 32'd0);
   endtask

   task automatic t_wait_abort();
      clr();
      dev_req = 1'b0;
      cfg(2'd2, 1'b1, DEVA, 32'h40, 32'h0000_0002, 32'h1);
      repeat (8) @(negedge clk);
      chk("R8", "waits for device", 32'(state_o), 32'd2);
      chk("R8", "no access while waiting", 32'(n_rd), 32'd0);
      cfg(2'd0, 1'b0, 32'h0, 32'h0, 32'h0, 32'h0);
      chk("R10", "idle after stop", 32'(state_o), 32'd0);
      chk("R10", "mode after stop", 32'(mode_o), 32'd0);
      dev_req = 1'b1;
      repeat (10) @(negedge clk);
      chk("R10", "no later access", 32'(n_rd), 32'd0);
      chk("R10", "no pulses", 32'(n_irq + n_err + n_ack), 32'd0);
   endtask

   task automatic t_busy_ignore();
      clr();
      put32(8'h40, 32'h0101_0101); put32(8'h44, 32'h0202_0202);
      put32(8'h60, 32'hDEAD_0000);
      dev_req = 1'b0;
      cfg(2'd2, 1'b1, DEVA, 32'h40, 32'h0000_0002, 32'h0);
      repeat (3) @(negedge clk);
      cfg(2'd1, 1'b0, DEVA, 32'h60, 32'h0000_0001, 32'h80);
      chk("R13", "mode kept", 32'(mode_o), 32'd2);
      dev_req = 1'b1;
      wait_idle("R13");
      chk("R13", "original elements", 32'(n_dw), 32'd2);
      chk("R13", "original data", dev_log[1], 32'h0202_0202);
      chk("R13", "no fetch", 32'(n_rd), 32'd2);
   endtask

   task automatic t_bus_err();
      clr();
      put32(8'h40, 32'h1234_5678);
      err_addr = 32'h44;
      cfg(2'd2, 1'b1, DEVA, 32'h40, 32'h0000_0003, 32'h0);
      wait_idle("R11");
      chk("R11", "error pulse", 32'(n_err), 32'd1);
      chk("R11", "irq pulse", 32'(n_irq), 32'd1);
      chk("R11", "one element done", 32'(n_ack), 32'd1);
      chk("R11", "mode cleared", 32'(mode_o), 32'd0);
      clr();
      err_addr = 32'h84;
      put32(8'h80, DEVA);
      cfg(2'd1, 1'b0, 32'h0, 32'h0, 32'h0, 32'h80);
      wait_idle("R11");
      chk("R11", "fetch error pulse", 32'(n_err), 32'd1);
   endtask

   task automatic t_bad_size();
      clr();
      cfg(2'd2, 1'b1, DEVA, 32'h40, 32'h0000_1001, 32'h0);
      wait_idle("R4");
      chk("R4", "width code 1 rejected", 32'(n_err), 32'd1);
      chk("R4", "rejection irq", 32'(n_irq), 32'd1);
      cfg(2'd2, 1'b1, DEVA, 32'h40, 32'h0000_3400, 32'h0);
      wait_idle("R4");
      chk("R4", "byte count over limit", 32'(n_err), 32'd2);
      cfg(2'd2, 1'b1, DEVA, 32'h40, 32'h0000_0800, 32'h0);
      wait_idle("R4");
      chk("R4", "word count over limit", 32'(n_err), 32'd3);
      cfg(2'd2, 1'b1, DEVA, 32'h40, 32'h0001_0001, 32'h0);
      wait_idle("R4");
      chk("R4", "reserved bit set", 32'(n_err), 32'd4);
      chk("R4", "no data access", 32'(n_rd + n_dw), 32'd0);
      dev_req = 1'b0;
      cfg(2'd2, 1'b1, DEVA, 32'h40, 32'h0000_0400, 32'h0);
      repeat (4) @(negedge clk);
      chk("R4", "word count 0x400 accepted", 32'(state_o), 32'd2);
      cfg(2'd0, 1'b0, 32'h0, 32'h0, 32'h0, 32'h0);
      dev_req = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_zero_count();
      clr();
      cfg(2'd2, 1'b1, DEVA, 32'h40, 32'h0000_2000, 32'h1);
      wait_idle("R12");
      chk("R12", "zero count irq", 32'(n_irq), 32'd1);
      chk("R12", "zero count no access", 32'(n_rd + n_dw + n_ack), 32'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      n_chk = 0; n_fail = 0;
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
      clr();
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_single_m2d();
      t_chain_d2m();
      t_single_ignores_link();
      t_wait_abort();
      t_busy_ignore();
      t_bus_err();
      t_bad_size();
      t_zero_count();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule